// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block pulls 16-bit instruction words from a synchronous memory read port, works out how long each instruction is, and hands the decoded fields to downstream control with a one-cycle valid pulse. The program counter starts at a reset vector parameter. Each accepted start request fetches exactly one instruction. The address register is loaded from the program counter, the word is read, and the counter steps by one for every word accepted. The first word goes into an instruction register.

The two type bits of the first word set the length. Branch instructions and memory-register instructions take a second word, which is kept in a separate register. The exception is a memory-register word with its single-operand bit set. Register-register and implied instructions are one word. The field outputs are masked by type, so that downstream logic only sees the fields that belong to the current format. A nonzero low byte on a branch or implied word raises an illegal flag, and the length rule stays the same.

The control is a four-state machine. `IDLE` waits for start. `WORD1` reads the first word. `WORD2` reads the trailing word. `EMIT` presents the instruction. The transitions are:
- START: `IDLE` to `WORD1` on start.
- SHORT: `WORD1` to `EMIT` for one-word instructions.
- LONG: `WORD1` to `WORD2` for two-word instructions.
- TAIL: `WORD2` to `EMIT`.
- CHAIN: `EMIT` to `WORD1` on start.
- DONE: `EMIT` to `IDLE` when there is no start.

Top module: `ifetch_unit`

## Requirements
- R1: After reset, ready_o is 1, mem_req_o is 0 and ins_valid_o is 0.
- R2: A read is completed in a cycle where mem_req_o and mem_rvalid_i are both high. mem_addr_o equals the program counter, which advances by one per completed read, starting from RESET_PC. While mem_rvalid_i is low, mem_req_o stays high and mem_addr_o holds its value.
- R3: ins_type_o is bits 15:14 of the first word (00 register-register, 01 memory-register, 10 branch, 11 implied), and ins_opcode_o is bits 13:8.
- R4: For type 00, ins_dst_reg_o is bits 2:0, ins_dst_ind_o is bit 3, ins_src_reg_o is bits 6:4 and ins_src_ind_o is bit 7. ins_mode_o and ins_form_o read 0. Word 0x0952 gives source 5, destination 2, both direct, opcode 0x09.
- R5: For type 01, ins_dst_reg_o is bits 2:0, ins_dst_ind_o is bit 3, ins_mode_o is bits 5:4 and ins_form_o is bits 7:6, and the source fields read 0. A second word is fetched unless bit 6 is 1. Word 0x4902 gives register 2, mode 00, and two words.
- R6: Type 10 always fetches a second word and type 11 never does. ins_two_word_o reports the length. ins_word2_o carries the second word, or 0 for one-word instructions. For types 10 and 11, all register, flag, mode and form fields read 0.
- R7: ins_illegal_o is 1 only for types 10 or 11 with a nonzero bits 7:0. Such a word is still fetched and emitted with its normal length.
- R8: ins_valid_o is a one-cycle pulse. ready_o is high only in IDLE and EMIT, and start_i is ignored while ready_o is low. The decoded outputs hold until the next instruction is latched.
- R9: mem_rvalid_i asserted while mem_req_o is low has no effect on state, outputs or the program counter.
- R10: A start_i in the cycle of ins_valid_o begins the next fetch at once, at the address after the last word read.
- R11: ins_pc_o is the address of the first word of the presented instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to fetch one instruction |
| ready_o | output | 1 | Unit can accept start_i |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid, completes a requested read |
| mem_rdata_i | input | 16 | Read data word |
| ins_valid_o | output | 1 | Decoded instruction valid pulse |
| ins_pc_o | output | AW | Address of the first word |
| ins_type_o | output | 2 | Instruction type bits |
| ins_opcode_o | output | 6 | Opcode |
| ins_dst_reg_o | output | 3 | Destination / memory-register register number |
| ins_dst_ind_o | output | 1 | Destination indirect flag |
| ins_src_reg_o | output | 3 | Source register number |
| ins_src_ind_o | output | 1 | Source indirect flag |
| ins_mode_o | output | 2 | Addressing mode field |
| ins_form_o | output | 2 | Operand-count / direction field |
| ins_two_word_o | output | 1 | Instruction was two words long |
| ins_word2_o | output | 16 | Second word, or zero |
| ins_illegal_o | output | 1 | Nonzero low byte on a branch or implied word |

## Verification
Presenting one instruction and starting the fetch of the next can fall in the same cycle. The bench raises start_i exactly in the cycle where ins_valid_o is high. It then confirms three things: the presented fields are still those of the current instruction, the next read goes to the address after its last word, and the chained instruction decodes correctly. A second coincidence is a memory valid arriving while no read is outstanding. The bench drives mem_rvalid_i with junk data during idle cycles and checks that the held outputs and the next fetch address do not change.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int WORD_W  = 16;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 3;

    // bit positions inside the first instruction word
    localparam int TYPE_LSB = 14;
    localparam int OPC_LSB  = 8;
    localparam int DST_LSB  = 0;
    localparam int DIND_BIT = 3;
    localparam int SRC_LSB  = 4;
    localparam int SIND_BIT = 7;
    localparam int MODE_LSB = 4;
    localparam int FORM_LSB = 6;
    localparam int ONEOP_BIT = 6;
    localparam int LOWB_W   = 8;

    typedef enum logic [1:0] {
        ITYPE_RR  = 2'b00,
        ITYPE_MR  = 2'b01,
        ITYPE_BR  = 2'b10,
        ITYPE_IMP = 2'b11
    } itype_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WORD1 = 2'd1,
        ST_WORD2 = 2'd2,
        ST_EMIT  = 2'd3
    } fstate_e;

    typedef struct packed {
        itype_e            kind;
        logic [OPC_W-1:0]  opc;
        logic [REG_W-1:0]  dreg;
        logic              dind;
        logic [REG_W-1:0]  sreg;
        logic              sind;
        logic [1:0]        mode;
        logic [1:0]        form;
    } ifields_t;

endpackage

// File: rtl/ifu_len_decode.sv
module ifu_len_decode
    import ifu_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              two_word_o,
    output logic              illegal_o
);

    itype_e kind;
    logic   low_nonzero;

    always_comb begin
        kind        = itype_e'(word_i[TYPE_LSB +: 2]);
        low_nonzero = |word_i[LOWB_W-1:0];
        two_word_o  = 1'b0;
        illegal_o   = 1'b0;
        unique case (kind)
            ITYPE_RR:  two_word_o = 1'b0;
            ITYPE_MR:  two_word_o = ~word_i[ONEOP_BIT];
            ITYPE_BR: begin
                two_word_o = 1'b1;
                illegal_o  = low_nonzero;
            end
            ITYPE_IMP: begin
                two_word_o = 1'b0;
                illegal_o  = low_nonzero;
            end
        endcase
    end

endmodule

// File: rtl/ifu_field_extract.sv
module ifu_field_extract
    import ifu_pkg::*;
(
    input  logic [WORD_W-1:0] ir_i,
    output ifields_t          fields_o
);

    always_comb begin
        fields_o      = '0;
        fields_o.kind = itype_e'(ir_i[TYPE_LSB +: 2]);
        fields_o.opc  = ir_i[OPC_LSB +: OPC_W];
        unique case (fields_o.kind)
            ITYPE_RR: begin
                fields_o.dreg = ir_i[DST_LSB +: REG_W];
                fields_o.dind = ir_i[DIND_BIT];
                fields_o.sreg = ir_i[SRC_LSB +: REG_W];
                fields_o.sind = ir_i[SIND_BIT];
            end
            ITYPE_MR: begin
                fields_o.dreg = ir_i[DST_LSB +: REG_W];
                fields_o.dind = ir_i[DIND_BIT];
                fields_o.mode = ir_i[MODE_LSB +: 2];
                fields_o.form = ir_i[FORM_LSB +: 2];
            end
            ITYPE_BR:  fields_o.opc = ir_i[OPC_LSB +: OPC_W];
            ITYPE_IMP: fields_o.opc = ir_i[OPC_LSB +: OPC_W];
        endcase
    end

endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_ar_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] first_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] ar_q;
    logic [AW-1:0] first_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pc_q    <= RESET_PC;
            ar_q    <= RESET_PC;
            first_q <= RESET_PC;
        end else begin
            if (load_ar_i) begin
                ar_q    <= pc_q;
                first_q <= pc_q;
            end
            if (step_i) begin
                pc_q <= pc_q + ONE;
                ar_q <= pc_q + ONE;
            end
        end
    end

    assign addr_o  = ar_q;
    assign first_o = first_q;

endmodule

// File: rtl/ifu_seq.sv
module ifu_seq
    import ifu_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic rvalid_i,
    input  logic two_word_i,
    output logic ready_o,
    output logic req_o,
    output logic load_ar_o,
    output logic step_o,
    output logic cap_ir_o,
    output logic cap_w2_o,
    output logic valid_o
);

    fstate_e state_q;
    fstate_e state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_WORD1;
            ST_WORD1: if (rvalid_i) state_d = two_word_i ? ST_WORD2 : ST_EMIT;
            ST_WORD2: if (rvalid_i) state_d = ST_EMIT;
            ST_EMIT:  state_d = start_i ? ST_WORD1 : ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o   = 1'b0;
        req_o     = 1'b0;
        load_ar_o = 1'b0;
        step_o    = 1'b0;
        cap_ir_o  = 1'b0;
        cap_w2_o  = 1'b0;
        valid_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o   = 1'b1;
                load_ar_o = start_i;
            end
            ST_WORD1: begin
                req_o    = 1'b1;
                step_o   = rvalid_i;
                cap_ir_o = rvalid_i;
            end
            ST_WORD2: begin
                req_o    = 1'b1;
                step_o   = rvalid_i;
                cap_w2_o = rvalid_i;
            end
            ST_EMIT: begin
                ready_o   = 1'b1;
                valid_o   = 1'b1;
                load_ar_o = start_i;
            end
        endcase
    end

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              ready_o,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              ins_valid_o,
    output logic [AW-1:0]     ins_pc_o,
    output logic [1:0]        ins_type_o,
    output logic [OPC_W-1:0]  ins_opcode_o,
    output logic [REG_W-1:0]  ins_dst_reg_o,
    output logic              ins_dst_ind_o,
    output logic [REG_W-1:0]  ins_src_reg_o,
    output logic              ins_src_ind_o,
    output logic [1:0]        ins_mode_o,
    output logic [1:0]        ins_form_o,
    output logic              ins_two_word_o,
    output logic [WORD_W-1:0] ins_word2_o,
    output logic              ins_illegal_o
);

    logic load_ar, step, cap_ir, cap_w2;
    logic nxt_two, nxt_ill;

    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] w2_q;
    logic              two_q;
    logic              ill_q;
    ifields_t          fld;

    ifu_len_decode u_len (
        .word_i     (mem_rdata_i),
        .two_word_o (nxt_two),
        .illegal_o  (nxt_ill)
    );

    ifu_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .rvalid_i   (mem_rvalid_i),
        .two_word_i (nxt_two),
        .ready_o    (ready_o),
        .req_o      (mem_req_o),
        .load_ar_o  (load_ar),
        .step_o     (step),
        .cap_ir_o   (cap_ir),
        .cap_w2_o   (cap_w2),
        .valid_o    (ins_valid_o)
    );

    ifu_pc_reg #(
        .AW       (AW),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_ar_i (load_ar),
        .step_i    (step),
        .addr_o    (mem_addr_o),
        .first_o   (ins_pc_o)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ir_q  <= '0;
            w2_q  <= '0;
            two_q <= 1'b0;
            ill_q <= 1'b0;
        end else begin
            if (cap_ir) begin
                ir_q  <= mem_rdata_i;
                w2_q  <= '0;
                two_q <= nxt_two;
                ill_q <= nxt_ill;
            end
            if (cap_w2) begin
                w2_q <= mem_rdata_i;
            end
        end
    end

    ifu_field_extract u_fx (
        .ir_i     (ir_q),
        .fields_o (fld)
    );

    assign ins_type_o     = fld.kind;
    assign ins_opcode_o   = fld.opc;
    assign ins_dst_reg_o  = fld.dreg;
    assign ins_dst_ind_o  = fld.dind;
    assign ins_src_reg_o  = fld.sreg;
    assign ins_src_ind_o  = fld.sind;
    assign ins_mode_o     = fld.mode;
    assign ins_form_o     = fld.form;
    assign ins_two_word_o = two_q;
    assign ins_word2_o    = w2_q;
    assign ins_illegal_o  = ill_q;

endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
    parameter int AW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ready_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rvalid_i,
    input logic          ins_valid_o,
    input logic [1:0]    ins_type_o,
    input logic [2:0]    ins_src_reg_o,
    input logic          ins_src_ind_o,
    input logic          ins_two_word_o,
    input logic [15:0]   ins_word2_o,
    input logic          ins_illegal_o
);

    p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_rvalid_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(1))));

    p_ready_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> !mem_req_o);

    p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_valid_o |=> !ins_valid_o);

    p_mr_src_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins_valid_o && ins_type_o == 2'b01) |-> (ins_src_reg_o == 3'd0 && !ins_src_ind_o));

    p_short_w2_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins_valid_o && !ins_two_word_o) |-> (ins_word2_o == 16'h0000));

    p_imp_short_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins_valid_o && ins_type_o == 2'b11) |-> !ins_two_word_o);

    p_low_types_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ins_valid_o && !ins_type_o[1]) |-> !ins_illegal_o);

endmodule

bind ifetch_unit ifu_checker #(.AW(AW)) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ready_o        (ready_o),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .mem_rvalid_i   (mem_rvalid_i),
    .ins_valid_o    (ins_valid_o),
    .ins_type_o     (ins_type_o),
    .ins_src_reg_o  (ins_src_reg_o),
    .ins_src_ind_o  (ins_src_ind_o),
    .ins_two_word_o (ins_two_word_o),
    .ins_word2_o    (ins_word2_o),
    .ins_illegal_o  (ins_illegal_o)
);

// File: tb/ifetch_unit_tb_top.sv
`timescale 1ns/1ps
module ifetch_unit_tb_top;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready;
    logic          req;
    logic [AW-1:0] addr;
    logic          rvalid = 1'b0;
    logic [15:0]   rdata = 16'h0000;
    logic          valid;
    logic [AW-1:0] ipc;
    logic [1:0]    itype;
    logic [5:0]    opc;
    logic [2:0]    dreg;
    logic          dind;
    logic [2:0]    sreg;
    logic          sind;
    logic [1:0]    mode;
    logic [1:0]    form;
    logic          two;
    logic [15:0]   w2;
    logic          ill;

    always #2 clk = ~clk;

    ifetch_unit #(.AW(AW), .RESET_PC('0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_o(ready),
        .mem_req_o(req), .mem_addr_o(addr), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
        .ins_valid_o(valid), .ins_pc_o(ipc), .ins_type_o(itype), .ins_opcode_o(opc),
        .ins_dst_reg_o(dreg), .ins_dst_ind_o(dind), .ins_src_reg_o(sreg), .ins_src_ind_o(sind),
        .ins_mode_o(mode), .ins_form_o(form), .ins_two_word_o(two), .ins_word2_o(w2),
        .ins_illegal_o(ill)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [15:0] mem [0:31];
    int          stall_cfg = 0;
    int          stall_cnt = 0;
    bit          noise = 1'b0;
    logic [AW-1:0] log_addr [0:7];
    int          log_n = 0;

    // memory model: answers at negedges, read completes at the following posedge
    always @(negedge clk) begin
        if (req) begin
            if (stall_cnt >= stall_cfg) begin
                rvalid = 1'b1;
                rdata  = mem[addr[4:0]];
                if (log_n < 8) log_addr[log_n] = addr;
                log_n++;
                stall_cnt = 0;
            end else begin
                rvalid = 1'b0;
                rdata  = 16'hDEAD;
                stall_cnt++;
            end
        end else begin
            rvalid    = noise;
            rdata     = 16'hF0F5;
            stall_cnt = 0;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog run did not finish");
        report();
    end

    task automatic pulse_start();
        @(negedge clk);
        log_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(input string rq);
        bit seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(rq, "valid seen", int'(seen), 1);
    endtask

    task automatic check_ins(input string rq, input int pc, input int words,
                             input int t, input int oc, input int dr, input int di,
                             input int sr, input int si, input int md, input int fm,
                             input int wd2, input int il);
        chk(rq, "ins_pc", int'(ipc), pc);
        chk(rq, "reads", log_n, words);
        chk(rq, "addr0", int'(log_addr[0]), pc);
        if (words == 2) chk(rq, "addr1", int'(log_addr[1]), pc + 1);
        chk(rq, "type", int'(itype), t);
        chk(rq, "opcode", int'(opc), oc);
        chk(rq, "dst_reg", int'(dreg), dr);
        chk(rq, "dst_ind", int'(dind), di);
        chk(rq, "src_reg", int'(sreg), sr);
        chk(rq, "src_ind", int'(sind), si);
        chk(rq, "mode", int'(mode), md);
        chk(rq, "form", int'(form), fm);
        chk(rq, "two_word", int'(two), (words == 2) ? 1 : 0);
        chk(rq, "word2", int'(w2), wd2);
        chk(rq, "illegal", int'(ill), il);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", int'(ready), 1);
        chk("R1", "req", int'(req), 0);
        chk("R1", "valid", int'(valid), 0);
    endtask

    // R4 R3: register-register word 0x0952 at address 0
    task automatic t_rr();
        pulse_start();
        wait_valid("R4");
        check_ins("R4", 0, 1, 0, 9, 2, 0, 5, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R8", "valid pulse low", int'(valid), 0);
    endtask

    // R5: memory-register 0x4902 + 0x1234 at address 1
    task automatic t_mr_long();
        pulse_start();
        wait_valid("R5");
        check_ins("R5", 1, 2, 1, 9, 2, 0, 0, 0, 0, 0, 16'h1234, 0);
    endtask

    // R2 R8 R5: one-operand form 0x4972 at address 3, stalled memory, start during stall ignored
    task automatic t_mr_short_stall();
        logic [AW-1:0] held;
        stall_cfg = 3;
        pulse_start();
        held = addr;
        chk("R2", "first addr", int'(held), 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2", "req held", int'(req), 1);
            chk("R2", "addr held", int'(addr), int'(held));
            chk("R8", "ready low", int'(ready), 0);
            start = (i < 2);
            @(negedge clk);
        end
        start = 1'b0;
        wait_valid("R5");
        check_ins("R5", 3, 1, 1, 9, 2, 0, 0, 0, 3, 1, 0, 0);
        stall_cfg = 0;
        repeat (3) @(negedge clk);
        chk("R8", "no extra fetch", int'(req), 0);
        chk("R8", "ready after", int'(ready), 1);
    endtask

    // R6: branch 0x8A00 + 0x0040 at address 4, then R9 noise in idle
    task automatic t_branch_noise();
        pulse_start();
        wait_valid("R6");
        check_ins("R6", 4, 2, 2, 10, 0, 0, 0, 0, 0, 0, 16'h0040, 0);
        @(negedge clk);
        noise = 1'b1;
        repeat (6) @(negedge clk);
        noise = 1'b0;
        chk("R9", "ready", int'(ready), 1);
        chk("R9", "req", int'(req), 0);
        chk("R9", "valid", int'(valid), 0);
        chk("R9", "opcode held", int'(opc), 10);
        chk("R9", "word2 held", int'(w2), 16'h0040);
        chk("R9", "type held", int'(itype), 2);
        chk("R9", "illegal held", int'(ill), 0);
    endtask

    // R6 R7 R11: implied 0xC000 at 6, illegal implied 0xC005 at 7
    task automatic t_implied();
        pulse_start();
        wait_valid("R6");
        check_ins("R6", 6, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        pulse_start();
        wait_valid("R7");
        check_ins("R7", 7, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    // R7 R10: illegal branch 0x8A81 at 8 chained with 0x095A at 10
    task automatic t_chain();
        pulse_start();
        wait_valid("R7");
        check_ins("R7", 8, 2, 2, 10, 0, 0, 0, 0, 0, 0, 16'h0077, 1);
        log_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "chained req", int'(req), 1);
        chk("R10", "chained addr", int'(addr), 10);
        wait_valid("R10");
        check_ins("R10", 10, 1, 0, 9, 2, 1, 5, 0, 0, 0, 0, 0);
    endtask

    // R5 R11: 0x4BB5 + 0xBEEF at 11 (bit 6 clear, two words)
    task automatic t_mr_form();
        pulse_start();
        wait_valid("R5");
        check_ins("R11", 11, 2, 1, 11, 5, 0, 0, 0, 3, 2, 16'hBEEF, 0);
        @(negedge clk);
        chk("R2", "next pc addr", int'(addr), 13);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'h0000;
        mem[0]  = 16'h0952;
        mem[1]  = 16'h4902;
        mem[2]  = 16'h1234;
        mem[3]  = 16'h4972;
        mem[4]  = 16'h8A00;
        mem[5]  = 16'h0040;
        mem[6]  = 16'hC000;
        mem[7]  = 16'hC005;
        mem[8]  = 16'h8A81;
        mem[9]  = 16'h0077;
        mem[10] = 16'h095A;
        mem[11] = 16'h4BB5;
        mem[12] = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rr();
        t_mr_long();
        t_mr_short_stall();
        t_branch_noise();
        t_implied();
        t_chain();
        t_mr_form();
        repeat (2) @(negedge clk);
        report();
    end

endmodule